// File: doc/BRIEF.md
# Nine-bit framed SPI command packer

This block sends short command transactions to a display controller over a byte-wide SPI link. A client presents one 32-bit descriptor on a valid/ready input. The top two bits of the descriptor give a parameter count of zero, one or two. The bits below hold the command byte and any parameter bytes, and each of these bytes already carries a flag bit in front of it: 0 marks the command and 1 marks a parameter. Every byte therefore becomes a 9-bit item. The block packs those items back to back, most significant bit first, into a frame of 2, 3 or 4 bytes. It pads the remainder of the last byte with zeros and shifts the frame out in SPI mode 3, with chip select held low for the whole frame.

The serial clock comes from a parameter-set divider of the system clock. After each frame, chip select is released and kept high for a programmable number of half periods before the next descriptor can be taken. A done pulse marks the end of each transaction. A descriptor whose count field is 3 is accepted and dropped: no bus activity takes place, and its done pulse follows on the next cycle.

Top module: `n9_spi_packer`

## Requirements
- R1: The count field in bits [31:30] sets the frame length: value 0 gives 16 clocked bits, 1 gives 24 and 2 gives 32, all inside one chip-select-low window.
- R2: The items go out MSB first, command item first. The command item is a 0 flag followed by the command byte, taken from descriptor bits [8:0] for count 0, [17:9] for count 1 and [26:18] for count 2. Each parameter item is a 1 flag followed by its byte. With two parameters, the first comes from bits [17:9] and the last from [8:0]. With one parameter, it comes from [8:0]. Descriptor bits not named here have no effect on the wire.
- R3: The 7 − count bits that follow the last item in the final byte are sent as 0.
- R4: SPI mode 3 is used. The serial clock is high whenever chip select is high, and MOSI changes only while the serial clock is low, so it is stable at every rising edge.
- R5: Each frame is its own chip-select window. After a frame, chip select stays high for at least one serial clock period (2·DIV_HALF system clocks) before the next frame starts.
- R6: A descriptor with count 3 is accepted. Chip select stays high for it and the block sends nothing, and done pulses on the following cycle.
- R7: For a frame with count 0 to 2, in_ready is low from the cycle after acceptance until the done pulse. done lasts exactly one cycle.
- R8: After reset, chip select and the serial clock are high, in_ready is high and done is low.
- R9: Within a frame, consecutive rising serial clock edges are exactly 2·DIV_HALF system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_desc | input | 32 | Command descriptor |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench builds the block with DIV_HALF = 2 and GAP_HALVES = 2, so that every frame lasts only a few dozen cycles. This makes a full sweep practical: all 256 command values with no parameters, and 64 varied command and parameter patterns each with one and two parameters, with junk in the ignored descriptor bits. The small divider keeps the bench period and gap checks (4 clocks) distinct from the default build, and the short gap exercises back-to-back frames and skipped descriptors interleaved with real ones.

// File: rtl/n9_pkg.sv
package n9_pkg;
   localparam int unsigned DESC_W = 32;
   localparam logic [1:0] CNT_SKIP = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_TAIL,
      ST_GAP
   } n9_state_e;
endpackage

// File: rtl/n9_frame_pack.sv
// Turns a descriptor into a left-aligned frame word plus its bit length.
module n9_frame_pack
   import n9_pkg::*;
(
   input  logic [DESC_W-1:0] desc,
   output logic [DESC_W-1:0] frame,
   output logic [5:0]        nbits,
   output logic              skip
);
   logic [1:0] cnt;
   assign cnt = desc[DESC_W-1 -: 2];

   // Left shift by 23 - 9*count moves the first item to bit 31 and
   // leaves zero padding below the last item.
   always_comb begin
      skip  = (cnt == CNT_SKIP);
      frame = '0;
      nbits = '0;
      case (cnt)
         2'd0: begin frame = desc << 23; nbits = 6'd16; end
         2'd1: begin frame = desc << 14; nbits = 6'd24; end
         2'd2: begin frame = desc << 5;  nbits = 6'd32; end
         default: begin frame = '0; nbits = '0; end
      endcase
   end
endmodule

// File: rtl/n9_half_tick.sv
// Half-period strobe for the serial clock.
module n9_half_tick #(
   parameter int unsigned DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end

      if (DIV_HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!run)        cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == LAST);

         // R9: strobes are never adjacent when the divider exceeds one
         a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/n9_serial_fsm.sv
// Mode-3 shifter with chip-select framing and inter-frame gap.
module n9_serial_fsm
   import n9_pkg::*;
#(
   parameter int unsigned GAP_HALVES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DESC_W-1:0] frame,
   input  logic [5:0]        nbits,
   input  logic              skip,
   input  logic              tick,
   output logic              run,
   output logic              in_ready,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);
   localparam int unsigned GW = $clog2(GAP_HALVES + 1);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_HALVES - 1);

   generate
      if (GAP_HALVES < 2) begin : g_bad_gap
         $error("GAP_HALVES must be at least 2 (one serial clock period)");
      end
   endgenerate

   n9_state_e         state;
   logic [DESC_W-1:0] shreg;
   logic [5:0]        bits_left;
   logic              first;
   logic [GW-1:0]     gap_cnt;
   logic              accept;

   assign in_ready = (state == ST_IDLE);
   assign run      = (state != ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign mosi     = shreg[DESC_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bits_left <= '0;
         first     <= 1'b0;
         gap_cnt   <= '0;
         sclk      <= 1'b1;
         cs_n      <= 1'b1;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (skip) begin
                     done <= 1'b1;
                  end else begin
                     shreg     <= frame;
                     bits_left <= nbits;
                     first     <= 1'b1;
                     cs_n      <= 1'b0;
                     state     <= ST_SHIFT;
                  end
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (sclk) begin
                     sclk  <= 1'b0;
                     first <= 1'b0;
                     if (!first) shreg <= shreg << 1;
                  end else begin
                     sclk      <= 1'b1;
                     bits_left <= bits_left - 1'b1;
                     if (bits_left == 6'd1) state <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_n    <= 1'b1;
                  gap_cnt <= '0;
                  state   <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_cnt == GAP_LAST) begin
                     done  <= 1'b1;
                     shreg <= '0;
                     state <= ST_IDLE;
                  end else begin
                     gap_cnt <= gap_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4: clock parks high outside a frame
   a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R4: data moves only while the clock is low inside a frame
   a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$past(cs_n) && (mosi != $past(mosi))) |-> !sclk);

   // R5: chip select stays released after a frame ends
   a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);

   // R6: a skipped descriptor produces done without bus activity
   a_r6_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && skip) |=> (cs_n && done));

   // R7: busy after a real frame is accepted
   a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !skip) |=> !in_ready);

   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/n9_spi_packer.sv
module n9_spi_packer
   import n9_pkg::*;
#(
   parameter int unsigned DIV_HALF   = 4,
   parameter int unsigned GAP_HALVES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DESC_W-1:0] in_desc,
   output logic              spi_sclk,
   output logic              spi_mosi,
   output logic              spi_cs_n,
   output logic              done
);
   logic [DESC_W-1:0] frame;
   logic [5:0]        nbits;
   logic              skip;
   logic              run;
   logic              tick;

   n9_frame_pack u_pack (
      .desc  (in_desc),
      .frame (frame),
      .nbits (nbits),
      .skip  (skip)
   );

   n9_half_tick #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   n9_serial_fsm #(.GAP_HALVES(GAP_HALVES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .frame    (frame),
      .nbits    (nbits),
      .skip     (skip),
      .tick     (tick),
      .run      (run),
      .in_ready (in_ready),
      .done     (done),
      .sclk     (spi_sclk),
      .mosi     (spi_mosi),
      .cs_n     (spi_cs_n)
   );
endmodule

// File: tb/n9_spi_packer_test.sv
`timescale 1ns/1ps
module n9_spi_packer_test;
   localparam int DH = 2;
   localparam int GH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_desc = '0;
   logic        in_ready, spi_sclk, spi_mosi, spi_cs_n, done;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   n9_spi_packer #(.DIV_HALF(DH), .GAP_HALVES(GH)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_desc(in_desc), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_cs_n(spi_cs_n), .done(done)
   );

   // bus monitor, sampled away from the active edge
   logic [31:0] cap;
   int  capn = 0, frames = 0, cyc = 0, last_rise = -1, hi_run = 0, last_gap = 0;
   bit  per_bad = 0, prev_sclk = 1, prev_cs = 1;

   always @(negedge clk) begin
      cyc++;
      if (prev_cs && !spi_cs_n) begin
         frames++;
         cap = '0; capn = 0; per_bad = 0; last_rise = -1;
         last_gap = hi_run;
      end
      if (spi_cs_n) hi_run++; else hi_run = 0;
      if (!spi_cs_n && spi_sclk && !prev_sclk) begin
         if (capn < 32) cap[31-capn] = spi_mosi;
         capn++;
         if (last_rise >= 0 && (cyc - last_rise) != 2*DH) per_bad = 1;
         last_rise = cyc;
      end
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_desc(int c, logic [7:0] cmd, logic [7:0] p1,
                                           logic [7:0] p2, logic [31:0] junk);
      logic [31:0] d;
      case (c)
         0: d = (junk & 32'h3FFF_FE00) | {23'd0, 1'b0, cmd};
         1: d = 32'h4000_0000 | (junk & 32'h3FFC_0000) | ({24'd0, cmd} << 9) | 32'h100 | {24'd0, p1};
         2: d = 32'h8000_0000 | (junk & 32'h3800_0000) | ({24'd0, cmd} << 18) | 32'h2_0000
                | ({24'd0, p1} << 9) | 32'h100 | {24'd0, p2};
         default: d = 32'hC000_0000 | (junk & 32'h3FFF_FFFF);
      endcase
      return d;
   endfunction

   function automatic logic [31:0] exp_bits(int c, logic [7:0] cmd, logic [7:0] p1, logic [7:0] p2);
      logic [31:0] v = '0;
      logic [8:0]  it [3];
      int pos = 31;
      it[0] = {1'b0, cmd};
      it[1] = {1'b1, (c == 2) ? p1 : p1};
      it[2] = {1'b1, p2};
      for (int n = 0; n <= c; n++)
         for (int b = 8; b >= 0; b--) begin
            v[pos] = it[n][b];
            pos--;
         end
      return v;
   endfunction

   task automatic send(int c, logic [7:0] cmd, logic [7:0] p1, logic [7:0] p2, logic [31:0] junk);
      logic [31:0] d, e, padm;
      int f0, k, nb;
      d = mk_desc(c, cmd, p1, p2, junk);
      // with one parameter, its byte is p1 placed in [8:0]
      e = exp_bits(c, cmd, p1, (c == 2) ? p2 : p1);
      nb = 16 + 8*c;
      f0 = frames;
      @(negedge clk);
      in_desc = d; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (c != 3) check(in_ready == 1'b0, "R7 ready low after accept", {31'd0, in_ready}, 32'd0);
      k = 0;
      while (!done && k < 2000) begin @(negedge clk); k++; end
      check(done == 1'b1, "R7 done seen", {31'd0, done}, 32'd1);
      if (c == 3) begin
         check(frames == f0, "R6 skip sends nothing", frames, f0);
         check(spi_cs_n == 1'b1, "R6 cs stays high", {31'd0, spi_cs_n}, 32'd1);
      end else begin
         check(capn == nb, "R1 frame length", capn, nb);
         check(cap == e, "R2 item content", cap, e);
         padm = '0;
         for (int b = 32 - nb; b <= 31 - 9*(c+1); b++) padm[b] = 1'b1;
         check((cap & padm) == '0, "R3 zero padding", cap & padm, 32'd0);
         check(!per_bad, "R9 sclk period", {31'd0, per_bad}, 32'd0);
         if (f0 > 0) check(last_gap >= 2*DH, "R5 cs gap", last_gap, 2*DH);
      end
      @(negedge clk);
      check(done == 1'b0, "R7 done single cycle", {31'd0, done}, 32'd0);
   endtask

   initial begin
      #(200000 * 4);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check(spi_cs_n && spi_sclk && in_ready && !done, "R8 reset state",
            {28'd0, spi_cs_n, spi_sclk, in_ready, done}, 32'hE);
      for (int i = 0; i < 256; i++)
         send(0, i[7:0], 8'h00, 8'h00, 32'h2AAA_5555 ^ (i * 32'h0101_0101));
      for (int i = 0; i < 64; i++)
         send(1, 8'(i*37+5), 8'(i*11) ^ 8'hA5, 8'h00, 32'h1555_AAAA ^ (i * 32'h0303_0303));
      for (int i = 0; i < 64; i++) begin
         send(2, 8'(i*53), ~8'(i*7), 8'(i*29+3), 32'h3FFF_FFFF ^ (i * 32'h0505_0505));
         if (i % 8 == 0) send(3, 8'hFF, 8'hFF, 8'hFF, 32'h1234_5678 + i);
      end
      // R5/R6: skip between back-to-back frames
      send(2, 8'hFF, 8'hFF, 8'hFF, 32'h0);
      send(3, 8'h00, 8'h00, 8'h00, 32'h3FFF_FFFF);
      send(0, 8'h00, 8'h00, 8'h00, 32'h3FFF_FFFF);
      send(1, 8'h80, 8'h01, 8'h00, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule